// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits in front of a DRAM command path and decides which pending request goes next, and which command it needs. Requests enter an eight-slot queue, each carrying a bank index and a row index. Slot order is arrival order, and slot 0 always holds the oldest request. The block tracks, for every bank, whether a row is open, which row it is, and how many column accesses that row has served since it was activated.

Two selection modes are chosen at runtime. Strict oldest-first always serves slot 0. Row-hit-first serves the oldest request that targets an already open row, and falls back to the oldest request when no such request is queued. A page policy, also chosen at runtime, decides after each column access whether the bank is precharged at once. A per-row access cap forces a precharge once an open row has been used `ROW_CAP` times. Timing constraints between commands and the data path belong to neighbouring blocks.

The control state machine has five states. `ST_IDLE` picks a request when `issue_en` is high and the queue is not empty. It moves to `ST_COL` on a row hit, to `ST_ACT` when the bank is closed, and to `ST_PRE` on a row conflict. `ST_PRE` always moves to `ST_ACT`, and `ST_ACT` always moves to `ST_COL`. `ST_COL` retires the request and moves to `ST_CLOSE` when the row must be shut, otherwise back to `ST_IDLE`. `ST_CLOSE` issues the trailing precharge and returns to `ST_IDLE`.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty (`q_cnt`=0, `q_full`=0), no command is issued (`cmd_valid`=0, `cmd_kind`=0), and every bank is closed, so the first request to any bank is served by ACT then COL, with no PRE.
- R2: The queue holds `DEPTH` (8) requests. `q_full` is high when `q_cnt` equals `DEPTH`, and a push while full is dropped and leaves `q_cnt` unchanged.
- R3: While `issue_en` is low and the state machine is in `ST_IDLE`, no command is issued and queued requests stay queued.
- R4: With `sched_mode`=0 (strict oldest-first), requests are served in arrival order.
- R5: With `sched_mode`=1 (row-hit-first), the oldest queued request whose row is open in its bank is served first. When no such request is queued, the oldest request is served.
- R6: `cmd_kind` encodes 0=none, 1=ACT, 2=COL, 3=PRE. A request to a closed bank gets ACT then COL. A request to an open row gets COL only. A request that conflicts with the open row gets PRE (carrying the open row) then ACT then COL. At most one command is issued per cycle.
- R7: With `page_pol`=0 (open), the row stays open after a column access unless the cap forces it shut.
- R8: With `page_pol`=2 (close), every COL is followed in the next cycle by PRE to the same bank.
- R9: With `page_pol`=1 (open-adaptive), the row is shut after a COL only when no other queued request hits it and some other queued request targets the same bank with a different row.
- R10: With `page_pol`=3 (close-adaptive), the row stays open after a COL only when another queued request hits it.
- R11: Once a row has served `ROW_CAP` COLs since its ACT, a PRE follows at once, even if further queued requests would hit it, under any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_mode | input | 1 | 0 = oldest-first, 1 = row-hit-first |
| page_pol | input | 2 | 0 open, 1 open-adaptive, 2 close, 3 close-adaptive |
| issue_en | input | 1 | Allows a new request to be picked |
| req_valid | input | 1 | Push a request this cycle |
| req_bank | input | BW | Bank of the pushed request |
| req_row | input | ROW_W | Row of the pushed request |
| q_full | output | 1 | Queue holds DEPTH requests |
| q_cnt | output | CW | Number of queued requests |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 0 none, 1 ACT, 2 COL, 3 PRE |
| cmd_bank | output | BW | Bank of the command |
| cmd_row | output | ROW_W | Row of the command (open row for PRE) |

## Verification
A wrong bank record shows up as an extra or missing PRE or ACT. The mismatch appears within the next request to that bank, and often within two cycles of the faulty update. A wrong pick, or a queue that compacts wrongly, reorders the COL stream or duplicates or loses a request, so the bench compares the full captured command sequence of each scenario against a list worked out by hand. A wrong access count or policy decision moves the trailing PRE by one COL, which is visible in the same cycle the decision is made.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_COL  = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        POL_OPEN      = 2'd0,
        POL_OPEN_ADP  = 2'd1,
        POL_CLOSE     = 2'd2,
        POL_CLOSE_ADP = 2'd3
    } pol_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_CLOSE
    } st_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
    parameter int DEPTH = 8,
    parameter int BW    = 3,
    parameter int RW    = 14,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [BW-1:0]             push_bank,
    input  logic [RW-1:0]             push_row,
    input  logic                      pop,
    input  logic [IW-1:0]             pop_idx,
    output logic [CW-1:0]             cnt,
    output logic                      full,
    output logic [DEPTH-1:0][BW-1:0]  slot_bank,
    output logic [DEPTH-1:0][RW-1:0]  slot_row
);
    logic [DEPTH-1:0][BW-1:0] nxt_bank;
    logic [DEPTH-1:0][RW-1:0] nxt_row;
    logic [CW-1:0]            after_pop;
    logic [CW-1:0]            nxt_cnt;

    assign full = (cnt == CW'(DEPTH));

    // compact the popped slot out, then append the new request behind the rest
    always_comb begin
        nxt_bank  = slot_bank;
        nxt_row   = slot_row;
        after_pop = cnt;
        if (pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (IW'(i) >= pop_idx) begin
                    nxt_bank[i] = slot_bank[(i == DEPTH-1) ? i : i+1];
                    nxt_row[i]  = slot_row[(i == DEPTH-1) ? i : i+1];
                end
            end
            after_pop = cnt - CW'(1);
        end
        nxt_cnt = after_pop;
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == after_pop) begin
                    nxt_bank[i] = push_bank;
                    nxt_row[i]  = push_row;
                end
            end
            nxt_cnt = after_pop + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            slot_bank <= '0;
            slot_row  <= '0;
        end else begin
            cnt       <= nxt_cnt;
            slot_bank <= nxt_bank;
            slot_row  <= nxt_row;
        end
    end

    // R2: a full queue without a pop stays full (dropped push)
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && !pop) |=> (cnt == CW'(DEPTH)));
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/bank_track.sv
module bank_track #(
    parameter int NBANK   = 8,
    parameter int RW      = 14,
    parameter int ROW_CAP = 16,
    localparam int BW     = $clog2(NBANK),
    localparam int AW     = $clog2(ROW_CAP + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      act_fire,
    input  logic                      col_fire,
    input  logic                      pre_fire,
    input  logic [BW-1:0]             bank,
    input  logic [RW-1:0]             row,
    output logic [NBANK-1:0]          open_vec,
    output logic [NBANK-1:0][RW-1:0]  open_rows,
    output logic                      last_col
);
    logic [NBANK-1:0][AW-1:0] acc;

    assign last_col = (acc[bank] == AW'(ROW_CAP - 1));

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic sel;
        assign sel = (bank == BW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vec[g]  <= 1'b0;
                open_rows[g] <= '0;
                acc[g]       <= '0;
            end else if (sel) begin
                if (act_fire) begin
                    open_vec[g]  <= 1'b1;
                    open_rows[g] <= row;
                    acc[g]       <= '0;
                end else if (pre_fire) begin
                    open_vec[g]  <= 1'b0;
                end else if (col_fire) begin
                    acc[g]       <= acc[g] + AW'(1);
                end
            end
        end

        // R11: the access count of an open row never passes the cap
        p_cap_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
            acc[g] <= AW'(ROW_CAP));
    end
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
    parameter int DEPTH = 8,
    parameter int NBANK = 8,
    parameter int RW    = 14,
    localparam int BW   = $clog2(NBANK),
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0]             cnt,
    input  logic [DEPTH-1:0][BW-1:0]  slot_bank,
    input  logic [DEPTH-1:0][RW-1:0]  slot_row,
    input  logic [NBANK-1:0]          open_vec,
    input  logic [NBANK-1:0][RW-1:0]  open_rows,
    input  logic                      hit_mode,
    input  logic [IW-1:0]             sel_idx,
    input  logic [BW-1:0]             sel_bank,
    input  logic [RW-1:0]             sel_row,
    output logic [IW-1:0]             pick_idx,
    output logic                      hit_other,
    output logic                      conf_other
);
    logic found;

    // lowest slot wins: slot order is age order
    always_comb begin
        pick_idx   = '0;
        found      = 1'b0;
        hit_other  = 1'b0;
        conf_other = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt) begin
                if (hit_mode && !found && open_vec[slot_bank[i]] &&
                    open_rows[slot_bank[i]] == slot_row[i]) begin
                    pick_idx = IW'(i);
                    found    = 1'b1;
                end
                if (IW'(i) != sel_idx && slot_bank[i] == sel_bank) begin
                    if (slot_row[i] == sel_row) hit_other  = 1'b1;
                    else                        conf_other = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
    import sched_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NBANK   = 8,
    parameter int ROW_W   = 14,
    parameter int ROW_CAP = 16,
    localparam int BW     = $clog2(NBANK),
    localparam int IW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_mode,
    input  logic [1:0]        page_pol,
    input  logic              issue_en,
    input  logic              req_valid,
    input  logic [BW-1:0]     req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              q_full,
    output logic [CW-1:0]     q_cnt,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BW-1:0]     cmd_bank,
    output logic [ROW_W-1:0]  cmd_row
);
    st_e                          st, st_nxt;
    logic [IW-1:0]                sel_idx, pick_idx;
    logic [BW-1:0]                sel_bank, pk_bank;
    logic [ROW_W-1:0]             sel_row, pk_row;
    logic [DEPTH-1:0][BW-1:0]     slot_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  slot_row;
    logic [NBANK-1:0]             open_vec;
    logic [NBANK-1:0][ROW_W-1:0]  open_rows;
    logic                         last_col, hit_other, conf_other, close_now;
    pol_e                         pol;
    cmd_e                         kind;

    assign pol     = pol_e'(page_pol);
    assign pk_bank = slot_bank[pick_idx];
    assign pk_row  = slot_row[pick_idx];

    sched_queue #(.DEPTH(DEPTH), .BW(BW), .RW(ROW_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid), .push_bank(req_bank), .push_row(req_row),
        .pop(st == ST_COL), .pop_idx(sel_idx),
        .cnt(q_cnt), .full(q_full),
        .slot_bank(slot_bank), .slot_row(slot_row)
    );

    bank_track #(.NBANK(NBANK), .RW(ROW_W), .ROW_CAP(ROW_CAP)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act_fire(st == ST_ACT), .col_fire(st == ST_COL),
        .pre_fire(st == ST_PRE || st == ST_CLOSE),
        .bank(sel_bank), .row(sel_row),
        .open_vec(open_vec), .open_rows(open_rows), .last_col(last_col)
    );

    sched_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .RW(ROW_W)) u_pick (
        .cnt(q_cnt), .slot_bank(slot_bank), .slot_row(slot_row),
        .open_vec(open_vec), .open_rows(open_rows), .hit_mode(sched_mode),
        .sel_idx(sel_idx), .sel_bank(sel_bank), .sel_row(sel_row),
        .pick_idx(pick_idx), .hit_other(hit_other), .conf_other(conf_other)
    );

    // post-access page decision, made in the COL cycle
    always_comb begin
        unique case (pol)
            POL_OPEN:      close_now = 1'b0;
            POL_OPEN_ADP:  close_now = !hit_other && conf_other;
            POL_CLOSE:     close_now = 1'b1;
            POL_CLOSE_ADP: close_now = !hit_other;
            default:       close_now = 1'b0;
        endcase
        close_now = close_now || last_col;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:
                if (issue_en && q_cnt != '0) begin
                    if (!open_vec[pk_bank])                st_nxt = ST_ACT;
                    else if (open_rows[pk_bank] == pk_row) st_nxt = ST_COL;
                    else                                   st_nxt = ST_PRE;
                end
            ST_PRE:   st_nxt = ST_ACT;
            ST_ACT:   st_nxt = ST_COL;
            ST_COL:   st_nxt = close_now ? ST_CLOSE : ST_IDLE;
            ST_CLOSE: st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sel_idx  <= '0;
            sel_bank <= '0;
            sel_row  <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE) begin
                sel_idx  <= pick_idx;
                sel_bank <= pk_bank;
                sel_row  <= pk_row;
            end
        end
    end

    always_comb begin
        kind     = CMD_NONE;
        cmd_bank = sel_bank;
        cmd_row  = sel_row;
        unique case (st)
            ST_IDLE:  cmd_bank = '0;
            ST_PRE:   begin kind = CMD_PRE; cmd_row = open_rows[sel_bank]; end
            ST_ACT:   kind = CMD_ACT;
            ST_COL:   kind = CMD_COL;
            ST_CLOSE: begin kind = CMD_PRE; cmd_row = open_rows[sel_bank]; end
            default:  kind = CMD_NONE;
        endcase
        if (st == ST_IDLE) cmd_row = '0;
        cmd_kind  = kind;
        cmd_valid = (kind != CMD_NONE);
    end

    // R6: command legality against the bank record
    p_col_hits_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_COL) |-> (open_vec[cmd_bank] && open_rows[cmd_bank] == cmd_row));
    p_act_on_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_ACT) |-> !open_vec[cmd_bank]);
    p_pre_on_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_PRE) |-> open_vec[cmd_bank]);
    // R8: close policy precharges right after each column access
    p_close_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_COL && page_pol == POL_CLOSE) |=>
        (cmd_kind == CMD_PRE && cmd_bank == $past(cmd_bank)));
    // R3: an idle, disabled scheduler issues nothing next cycle
    p_idle_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !issue_en) |=> (cmd_kind == CMD_NONE));
endmodule

// File: tb/test_rowhit_sched.sv
module test_rowhit_sched;
    localparam int BW = 3;
    localparam int RW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sched_mode = 1'b0;
    logic [1:0]    page_pol = 2'd0;
    logic          issue_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic          q_full;
    logic [3:0]    q_cnt;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [BW-1:0] cmd_bank;
    logic [RW-1:0] cmd_row;

    int total = 0;
    int bad   = 0;

    logic [1:0]    cap_k [64];
    logic [BW-1:0] cap_b [64];
    logic [RW-1:0] cap_r [64];
    int            ncap = 0;
    logic [1:0]    exp_k [64];
    logic [BW-1:0] exp_b [64];
    logic [RW-1:0] exp_r [64];
    int            nexp = 0;

    always #4 clk = ~clk;

    rowhit_sched #(.ROW_CAP(4)) i_rowhit_sched (
        .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .page_pol(page_pol),
        .issue_en(issue_en), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .q_full(q_full), .q_cnt(q_cnt), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
    );

    always @(negedge clk) begin
        if (rst_n && cmd_valid && ncap < 64) begin
            cap_k[ncap] = cmd_kind;
            cap_b[ncap] = cmd_bank;
            cap_r[ncap] = cmd_row;
            ncap = ncap + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; issue_en = 1'b0; req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        ncap = 0; nexp = 0;
    endtask

    task automatic push(input int b, input int r);
        req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(r);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic want(input int k, input int b, input int r);
        exp_k[nexp] = 2'(k); exp_b[nexp] = BW'(b); exp_r[nexp] = RW'(r);
        nexp++;
    endtask

    task automatic run_compare(input string req);
        issue_en = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        check({req, " command count"}, ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++) begin
            check({req, " kind"}, int'(cap_k[i]), int'(exp_k[i]));
            check({req, " bank"}, int'(cap_b[i]), int'(exp_b[i]));
            check({req, " row"},  int'(cap_r[i]), int'(exp_r[i]));
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 cmd_valid", int'(cmd_valid), 0);
        check("R1 cmd_kind", int'(cmd_kind), 0);
        check("R1 q_cnt", int'(q_cnt), 0);
        check("R1 q_full", int'(q_full), 0);
    endtask

    // R4 oldest-first under open policy (R7 keeps rows open, R6 conflicts)
    task automatic t_fcfs();
        do_reset(); sched_mode = 1'b0; page_pol = 2'd0;
        push(0, 1); push(1, 2); push(0, 3); push(0, 1);
        want(1,0,1); want(2,0,1); want(1,1,2); want(2,1,2);
        want(3,0,1); want(1,0,3); want(2,0,3);
        want(3,0,3); want(1,0,1); want(2,0,1);
        run_compare("R4/R6/R7");
    endtask

    // R5 row-hit-first pulls the later hit ahead
    task automatic t_hitfirst();
        do_reset(); sched_mode = 1'b1; page_pol = 2'd0;
        push(0, 1); push(1, 2); push(0, 3); push(0, 1);
        want(1,0,1); want(2,0,1); want(2,0,1);
        want(1,1,2); want(2,1,2);
        want(3,0,1); want(1,0,3); want(2,0,3);
        run_compare("R5");
    endtask

    task automatic t_close();
        do_reset(); sched_mode = 1'b0; page_pol = 2'd2;
        push(2, 7); push(2, 7);
        want(1,2,7); want(2,2,7); want(3,2,7);
        want(1,2,7); want(2,2,7); want(3,2,7);
        run_compare("R8");
    endtask

    task automatic t_close_adp();
        do_reset(); sched_mode = 1'b1; page_pol = 2'd3;
        push(2, 7); push(2, 7); push(3, 1);
        want(1,2,7); want(2,2,7); want(2,2,7); want(3,2,7);
        want(1,3,1); want(2,3,1); want(3,3,1);
        run_compare("R10");
    endtask

    task automatic t_open_adp();
        do_reset(); sched_mode = 1'b1; page_pol = 2'd1;
        push(4, 1); push(4, 2); push(5, 3);
        want(1,4,1); want(2,4,1); want(3,4,1);
        want(1,4,2); want(2,4,2);
        want(1,5,3); want(2,5,3);
        run_compare("R9 first");
        // row 2 of bank 4 must still be open: COL only
        issue_en = 1'b0; ncap = 0; nexp = 0;
        push(4, 2);
        want(2,4,2);
        run_compare("R9 still open");
    endtask

    task automatic t_cap();
        do_reset(); sched_mode = 1'b1; page_pol = 2'd0;
        for (int i = 0; i < 6; i++) push(6, 9);
        want(1,6,9);
        for (int i = 0; i < 4; i++) want(2,6,9);
        want(3,6,9); want(1,6,9); want(2,6,9); want(2,6,9);
        run_compare("R11");
    endtask

    task automatic t_gate_full();
        int cols;
        do_reset(); sched_mode = 1'b1; page_pol = 2'd0;
        push(7, 3);
        repeat (10) @(posedge clk);
        #1;
        check("R3 no command while disabled", ncap, 0);
        check("R3 request kept", int'(q_cnt), 1);
        for (int i = 0; i < 7; i++) push(7, 3);
        check("R2 full flag", int'(q_full), 1);
        check("R2 count at depth", int'(q_cnt), 8);
        push(7, 3);
        check("R2 push while full dropped", int'(q_cnt), 8);
        issue_en = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        cols = 0;
        for (int i = 0; i < ncap; i++) if (cap_k[i] == 2'd2) cols++;
        check("R2 served count", cols, 8);
        check("R2 queue drained", int'(q_cnt), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fcfs();
        t_hitfirst();
        t_close();
        t_close_adp();
        t_open_adp();
        t_cap();
        t_gate_full();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule